// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns a decoded operand descriptor into the address a load/store stage would use. Each request carries an addressing-mode code, an operand size code, a 32-bit address field, a 16-bit displacement, the value and index of the named pointer/base register, the value of an index register, the address of the next instruction, and an optional segment base. The block returns the effective address, a flag that says whether the operand lives in memory, and a register write-back request that commits the updated pointer for the auto-modifying modes.

A single unified adder serves every mode. A four-term sum combines a primary operand (address field, base register, auto-modified pointer or next-instruction address), an optionally scaled index, a sign-extended displacement and a segment base. A small decoder picks the terms for each mode. Results are registered once and offered through a valid/ready handshake. A result waiting on a stalled consumer holds still until it is taken.

Top module: `eag_top`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A request accepted on a clock edge is presented with `out_valid` high after that edge. An idle accepted output drops `out_valid`. Reset clears `out_valid`.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and every result output stay unchanged on the next cycle.
- R3: Mode codes 0 (literal operand), 2 (register direct) and the unused codes 12..15 give `out_mem`=0, `out_ea`=0 and `out_wb_en`=0, whatever the other inputs are.
- R4: Mode 1 (absolute) gives `out_ea` = `in_field` with `out_mem`=1 and no write-back.
- R5: Mode 3 (register indirect) gives `out_ea` = `in_base_val` with `out_mem`=1 and no write-back.
- R6: Modes 4 (post-increment) and 5 (post-decrement) give `out_ea` = `in_base_val`. They raise `out_wb_en`, with `out_wb_idx` = `in_reg_idx` and `out_wb_data` = `in_base_val` plus or minus the step.
- R7: Modes 6 (pre-increment) and 7 (pre-decrement) set both `out_ea` and `out_wb_data` to `in_base_val` plus or minus the step. They raise `out_wb_en` with `out_wb_idx` = `in_reg_idx`.
- R8: The step is taken from `in_size`: code 0 gives 1, code 1 gives 2, codes 2 and 3 give 4.
- R9: Mode 8 (indexed) gives `out_ea` = `in_field` + `in_index_val`, unscaled.
- R10: Mode 9 (base plus displacement) gives `out_ea` = `in_base_val` + sign-extended `in_disp`.
- R11: Mode 10 (PC-relative) gives `out_ea` = `in_pc_next` + sign-extended `in_disp`. Here `in_pc_next` is the address of the following instruction.
- R12: Mode 11 (base-indexed) gives `out_ea` = `in_base_val` + (`in_index_val` << `in_scale`) + sign-extended `in_disp` + (`in_seg_en` ? `in_seg_base` : 0). Scale codes 0..3 multiply by 1, 2, 4 and 8.
- R13: All address and pointer arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 4 | Addressing-mode code |
| in_size | input | 2 | Operand size code selecting the auto-modify step |
| in_scale | input | 2 | Index shift amount for base-indexed mode |
| in_field | input | 32 | Instruction address field |
| in_disp | input | 16 | Signed displacement |
| in_reg_idx | input | 4 | Number of the pointer/base register |
| in_base_val | input | 32 | Content of the pointer/base register |
| in_index_val | input | 32 | Content of the index register |
| in_pc_next | input | 32 | Address of the next instruction |
| in_seg_en | input | 1 | Add the segment base in base-indexed mode |
| in_seg_base | input | 32 | Segment base value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ea | output | 32 | Effective address |
| out_mem | output | 1 | Operand is in memory |
| out_wb_en | output | 1 | Pointer write-back request |
| out_wb_idx | output | 4 | Register to write back |
| out_wb_data | output | 32 | Updated pointer value |

## Verification
Random requests cover all sixteen mode codes with random register, field, displacement and segment values. Each result is compared with a bench model. The comparison tells apart pre- from post-modification and increment from decrement, and it shows whether the index is scaled in each mode. Directed cases push pointers across zero and across the top of the address space, use negative displacements against the next-instruction address, and try size code 3 and scale code 3. They also set every field while a non-memory mode is selected, to show that those fields leave the outputs at zero. The consumer's ready signal is toggled at random, so results are also checked on cycles where they must hold still.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int EAG_ADDR_W = 32;
    localparam int EAG_DISP_W = 16;
    localparam int EAG_RIDX_W = 4;

    typedef enum logic [3:0] {
        M_LIT      = 4'd0,
        M_ABS      = 4'd1,
        M_REG      = 4'd2,
        M_RIND     = 4'd3,
        M_POST_INC = 4'd4,
        M_POST_DEC = 4'd5,
        M_PRE_INC  = 4'd6,
        M_PRE_DEC  = 4'd7,
        M_INDEXED  = 4'd8,
        M_BASE_D   = 4'd9,
        M_PC_REL   = 4'd10,
        M_BASE_IDX = 4'd11
    } mode_e;

    typedef enum logic [2:0] {
        PRI_ZERO,
        PRI_FIELD,
        PRI_BASE,
        PRI_MODPTR,
        PRI_PC
    } pri_sel_e;

    typedef struct packed {
        logic     mem;
        logic     wb;
        logic     down;
        pri_sel_e pri;
        logic     add_idx;
        logic     scale_idx;
        logic     add_disp;
        logic     add_seg;
    } ctl_t;

    function automatic logic [2:0] step_of(input logic [1:0] size);
        case (size)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
(
    input  logic [3:0] mode,
    output ctl_t       ctl
);
    always_comb begin
        ctl = '{mem: 1'b0, wb: 1'b0, down: 1'b0, pri: PRI_ZERO,
                add_idx: 1'b0, scale_idx: 1'b0, add_disp: 1'b0, add_seg: 1'b0};
        case (mode)
            M_ABS: begin
                ctl.mem = 1'b1;
                ctl.pri = PRI_FIELD;
            end
            M_RIND: begin
                ctl.mem = 1'b1;
                ctl.pri = PRI_BASE;
            end
            M_POST_INC, M_POST_DEC: begin
                ctl.mem  = 1'b1;
                ctl.wb   = 1'b1;
                ctl.down = (mode == M_POST_DEC);
                ctl.pri  = PRI_BASE;
            end
            M_PRE_INC, M_PRE_DEC: begin
                ctl.mem  = 1'b1;
                ctl.wb   = 1'b1;
                ctl.down = (mode == M_PRE_DEC);
                ctl.pri  = PRI_MODPTR;
            end
            M_INDEXED: begin
                ctl.mem     = 1'b1;
                ctl.pri     = PRI_FIELD;
                ctl.add_idx = 1'b1;
            end
            M_BASE_D: begin
                ctl.mem      = 1'b1;
                ctl.pri      = PRI_BASE;
                ctl.add_disp = 1'b1;
            end
            M_PC_REL: begin
                ctl.mem      = 1'b1;
                ctl.pri      = PRI_PC;
                ctl.add_disp = 1'b1;
            end
            M_BASE_IDX: begin
                ctl.mem       = 1'b1;
                ctl.pri       = PRI_BASE;
                ctl.add_idx   = 1'b1;
                ctl.scale_idx = 1'b1;
                ctl.add_disp  = 1'b1;
                ctl.add_seg   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eag_step.sv
module eag_step
    import eag_pkg::*;
#(
    parameter int W = EAG_ADDR_W
) (
    input  logic [W-1:0] ptr,
    input  logic [1:0]   size,
    input  logic         down,
    output logic [W-1:0] moved
);
    logic [W-1:0] step;

    always_comb begin
        step  = W'(step_of(size));
        moved = down ? (ptr - step) : (ptr + step);
    end
endmodule

// File: rtl/eag_sum.sv
module eag_sum #(
    parameter int W     = 32,
    parameter int TERMS = 4
) (
    input  logic [TERMS-1:0][W-1:0] term,
    output logic [W-1:0]            total
);
    logic [TERMS:0][W-1:0] acc;

    assign acc[0] = '0;
    for (genvar g = 0; g < TERMS; g++) begin : g_add
        assign acc[g+1] = acc[g] + term[g];
    end
    assign total = acc[TERMS];
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
#(
    parameter int ADDR_W = EAG_ADDR_W,
    parameter int DISP_W = EAG_DISP_W,
    parameter int RIDX_W = EAG_RIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [3:0]        in_mode,
    input  logic [1:0]        in_size,
    input  logic [1:0]        in_scale,
    input  logic [ADDR_W-1:0] in_field,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [RIDX_W-1:0] in_reg_idx,
    input  logic [ADDR_W-1:0] in_base_val,
    input  logic [ADDR_W-1:0] in_index_val,
    input  logic [ADDR_W-1:0] in_pc_next,
    input  logic              in_seg_en,
    input  logic [ADDR_W-1:0] in_seg_base,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_ea,
    output logic              out_mem,
    output logic              out_wb_en,
    output logic [RIDX_W-1:0] out_wb_idx,
    output logic [ADDR_W-1:0] out_wb_data
);
    localparam int TERMS = 4;

    ctl_t                          ctl;
    logic [ADDR_W-1:0]             moved;
    logic [ADDR_W-1:0]             disp_x;
    logic [TERMS-1:0][ADDR_W-1:0]  term;
    logic [ADDR_W-1:0]             ea_sum;
    logic                          take;

    eag_decode u_dec (
        .mode (in_mode),
        .ctl  (ctl)
    );

    eag_step #(.W(ADDR_W)) u_step (
        .ptr   (in_base_val),
        .size  (in_size),
        .down  (ctl.down),
        .moved (moved)
    );

    assign disp_x = {{(ADDR_W-DISP_W){in_disp[DISP_W-1]}}, in_disp};

    always_comb begin
        case (ctl.pri)
            PRI_FIELD:  term[0] = in_field;
            PRI_BASE:   term[0] = in_base_val;
            PRI_MODPTR: term[0] = moved;
            PRI_PC:     term[0] = in_pc_next;
            default:    term[0] = '0;
        endcase
        if (!ctl.add_idx)
            term[1] = '0;
        else if (ctl.scale_idx)
            term[1] = in_index_val << in_scale;
        else
            term[1] = in_index_val;
        term[2] = ctl.add_disp ? disp_x : '0;
        term[3] = (ctl.add_seg && in_seg_en) ? in_seg_base : '0;
    end

    eag_sum #(.W(ADDR_W), .TERMS(TERMS)) u_sum (
        .term  (term),
        .total (ea_sum)
    );

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_ea      <= '0;
            out_mem     <= 1'b0;
            out_wb_en   <= 1'b0;
            out_wb_idx  <= '0;
            out_wb_data <= '0;
        end else if (take) begin
            out_valid   <= 1'b1;
            out_ea      <= ea_sum;
            out_mem     <= ctl.mem;
            out_wb_en   <= ctl.wb;
            out_wb_idx  <= ctl.wb ? in_reg_idx : '0;
            out_wb_data <= ctl.wb ? moved : '0;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end
endmodule

// File: rtl/eag_top_chk.sv
module eag_top_chk #(
    parameter int ADDR_W = 32,
    parameter int RIDX_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_ea,
    input logic              out_mem,
    input logic              out_wb_en,
    input logic [RIDX_W-1:0] out_wb_idx,
    input logic [ADDR_W-1:0] out_wb_data
);
    // R1
    ready_rule_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready == (!out_valid || out_ready));

    // R1
    accept_shows_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_ea) && $stable(out_mem)
            && $stable(out_wb_en) && $stable(out_wb_idx) && $stable(out_wb_data)));

    // R3
    nomem_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_mem) |-> (out_ea == '0 && !out_wb_en));

    // R6
    wb_needs_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_wb_en) |-> out_mem);
endmodule

bind eag_top eag_top_chk #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_ea      (out_ea),
    .out_mem     (out_mem),
    .out_wb_en   (out_wb_en),
    .out_wb_idx  (out_wb_idx),
    .out_wb_data (out_wb_data)
);

// File: tb/eag_top_bench.sv
`timescale 1ns/100ps
module eag_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_mode = '0;
    logic [1:0]  in_size = '0;
    logic [1:0]  in_scale = '0;
    logic [31:0] in_field = '0;
    logic [15:0] in_disp = '0;
    logic [3:0]  in_reg_idx = '0;
    logic [31:0] in_base_val = '0;
    logic [31:0] in_index_val = '0;
    logic [31:0] in_pc_next = '0;
    logic        in_seg_en = 1'b0;
    logic [31:0] in_seg_base = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_ea;
    logic        out_mem;
    logic        out_wb_en;
    logic [3:0]  out_wb_idx;
    logic [31:0] out_wb_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [31:0] ea;
        logic        mem;
        logic        wb;
        logic [3:0]  idx;
        logic [31:0] wbd;
        string       req;
    } exp_t;

    exp_t exp_q;
    bit   have = 1'b0;

    always #2.5 clk = ~clk;

    eag_top u_eag_top (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [3:0] m, input logic [1:0] sz,
        input logic [1:0] sc, input logic [31:0] f, input logic [15:0] d,
        input logic [3:0] ri, input logic [31:0] b, input logic [31:0] x,
        input logic [31:0] pc, input logic se, input logic [31:0] sb);
        exp_t e;
        logic [31:0] st, dx;
        st = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
        dx = 32'(signed'(d));
        e.ea = 0; e.mem = 1; e.wb = 0; e.idx = ri; e.wbd = 0; e.req = "R3";
        case (m)
            4'd1:  begin e.ea = f; e.req = "R4"; end
            4'd3:  begin e.ea = b; e.req = "R5"; end
            4'd4:  begin e.ea = b; e.wb = 1; e.wbd = b + st; e.req = "R6/R8"; end
            4'd5:  begin e.ea = b; e.wb = 1; e.wbd = b - st; e.req = "R6/R8"; end
            4'd6:  begin e.wb = 1; e.wbd = b + st; e.ea = e.wbd; e.req = "R7/R8"; end
            4'd7:  begin e.wb = 1; e.wbd = b - st; e.ea = e.wbd; e.req = "R7/R8"; end
            4'd8:  begin e.ea = f + x; e.req = "R9"; end
            4'd9:  begin e.ea = b + dx; e.req = "R10"; end
            4'd10: begin e.ea = pc + dx; e.req = "R11"; end
            4'd11: begin
                e.ea = b + (x * (32'd1 << sc)) + dx + (se ? sb : 32'd0);
                e.req = "R12";
            end
            default: e.mem = 0;
        endcase
        return e;
    endfunction

    // Called at a falling edge; applies inputs, checks, then waits one cycle.
    task automatic tick(input bit v, input bit rdy, input logic [3:0] m,
        input logic [1:0] sz, input logic [1:0] sc, input logic [31:0] f,
        input logic [15:0] d, input logic [3:0] ri, input logic [31:0] b,
        input logic [31:0] x, input logic [31:0] pc, input logic se,
        input logic [31:0] sb);
        bit fire_in, fire_out;
        in_valid = v; out_ready = rdy; in_mode = m; in_size = sz; in_scale = sc;
        in_field = f; in_disp = d; in_reg_idx = ri; in_base_val = b;
        in_index_val = x; in_pc_next = pc; in_seg_en = se; in_seg_base = sb;
        #1;
        check(out_valid == have, "R1 out_valid", 32'(out_valid), 32'(have));
        check(in_ready == (!out_valid || out_ready), "R1 in_ready",
              32'(in_ready), 32'(!out_valid || out_ready));
        if (out_valid && have) begin
            check(out_ea == exp_q.ea, {exp_q.req, "/R2/R13 ea"}, out_ea, exp_q.ea);
            check(out_mem == exp_q.mem, {exp_q.req, " mem"}, 32'(out_mem), 32'(exp_q.mem));
            check(out_wb_en == exp_q.wb, {exp_q.req, " wb_en"}, 32'(out_wb_en), 32'(exp_q.wb));
            if (exp_q.wb) begin
                check(out_wb_idx == exp_q.idx, {exp_q.req, " wb_idx"},
                      32'(out_wb_idx), 32'(exp_q.idx));
                check(out_wb_data == exp_q.wbd, {exp_q.req, "/R13 wb_data"},
                      out_wb_data, exp_q.wbd);
            end
        end
        fire_out = out_valid && out_ready;
        fire_in  = in_valid && in_ready;
        if (fire_out) have = 1'b0;
        if (fire_in) begin
            exp_q = model(m, sz, sc, f, d, ri, b, x, pc, se, sb);
            have  = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic one(input logic [3:0] m, input logic [1:0] sz, input logic [1:0] sc,
        input logic [31:0] f, input logic [15:0] d, input logic [3:0] ri,
        input logic [31:0] b, input logic [31:0] x, input logic [31:0] pc,
        input logic se, input logic [31:0] sb);
        tick(1'b1, 1'b1, m, sz, sc, f, d, ri, b, x, pc, se, sb);
        tick(1'b0, 1'b1, 4'd0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 1'b0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1 reset valid", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R1 reset ready", 32'(in_ready), 32'd1);
        @(negedge clk);

        // R3: non-memory modes ignore all fields
        one(4'd0, 2'd2, 2'd3, 32'hDEAD_BEEF, 16'h8001, 4'd7, 32'h1234_5678,
            32'h9, 32'h100, 1'b1, 32'h55);
        one(4'd2, 2'd1, 2'd1, 32'hFFFF_FFFF, 16'h7FFF, 4'd3, 32'hAAAA_AAAA,
            32'h3, 32'h4, 1'b1, 32'h77);
        one(4'd13, 2'd0, 2'd2, 32'h0000_1000, 16'h0004, 4'd1, 32'h0000_2000,
            32'h5, 32'h6, 1'b1, 32'h8);
        // R4, R5
        one(4'd1, 2'd0, 2'd0, 32'hCAFE_0000, 16'h1, 4'd2, 32'h11, 32'h22, 32'h33, 1'b0, 0);
        one(4'd3, 2'd0, 2'd0, 32'h0, 16'h0, 4'd5, 32'h8000_0000, 0, 0, 1'b0, 0);
        // R6, R13: post-decrement across zero
        one(4'd5, 2'd0, 2'd0, 0, 0, 4'd9, 32'h0, 0, 0, 1'b0, 0);
        // R7, R8, R13: pre-increment by 4 (size code 3) across top
        one(4'd6, 2'd3, 2'd0, 0, 0, 4'd15, 32'hFFFF_FFFE, 0, 0, 1'b0, 0);
        one(4'd7, 2'd1, 2'd0, 0, 0, 4'd4, 32'h0000_0100, 0, 0, 1'b0, 0);
        one(4'd4, 2'd2, 2'd0, 0, 0, 4'd6, 32'h0000_0200, 0, 0, 1'b0, 0);
        // R9: scale ignored in indexed
        one(4'd8, 2'd0, 2'd3, 32'h0000_1000, 0, 0, 0, 32'h10, 0, 1'b1, 32'h999);
        // R10, R11: negative displacement
        one(4'd9, 2'd0, 2'd0, 0, 16'hFFF0, 0, 32'h0000_0008, 0, 0, 1'b0, 0);
        one(4'd10, 2'd0, 2'd0, 0, 16'h8000, 0, 0, 0, 32'h0000_4004, 1'b0, 0);
        // R12: scale 8 with and without segment
        one(4'd11, 2'd0, 2'd3, 0, 16'h0010, 0, 32'h100, 32'h3, 0, 1'b1, 32'h1_0000);
        one(4'd11, 2'd0, 2'd3, 0, 16'h0010, 0, 32'h100, 32'h3, 0, 1'b0, 32'h1_0000);

        // Random traffic with random back-pressure (R2 stalls covered here)
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] b;
            b = ($urandom % 4 == 0) ? ($urandom % 8) - 32'd4 : $urandom;
            tick($urandom % 4 != 0, $urandom % 3 != 0, 4'($urandom), 2'($urandom),
                 2'($urandom), $urandom, 16'($urandom), 4'($urandom), b, $urandom,
                 $urandom, 1'($urandom), $urandom);
        end
        tick(1'b0, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0, 0);
        tick(1'b0, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0, 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule